// File: doc/BRIEF.md
# Predicated Vector Compare and Integer Add/Subtract Unit

This block is one slice of a vector datapath. It holds its own small file of predicate registers, one bit per lane. A compare instruction tests the two source vectors lane by lane and stores the true/false result of each lane in a chosen predicate register. An add or subtract instruction then names one of those registers as its predicate. Only the lanes whose predicate bit is set take the arithmetic result.

For each add or subtract, a mode flag decides what happens to lanes whose predicate bit is clear. In merge mode they keep the old destination value, which the surrounding vector register file supplies on `dst_old`. In zeroing mode they are written as zero.

The unit accepts one instruction per cycle. The result is registered and appears one cycle after the instruction is accepted, together with a one-cycle `done` pulse. The writeback port drives a simple vector register file. Predicate register 0 is special: as a predicate it always means "all lanes on", and it cannot be written.

Top module: `masked_lane_alu`

## Requirements
- R1: After reset `done`, `wb_en` and `wb_data` are 0 and predicate registers 1..NMASK-1 hold all zeros. An add that uses such a register in merge mode therefore returns `dst_old` unchanged.
- R2: Opcode 0 (add) computes `src_a + src_b` independently in each LW-bit lane (lane i at bits i*LW+:LW), wrapping modulo 2^LW with no carry between lanes.
- R3: Opcode 1 (subtract) computes `src_a - src_b` per lane, wrapping modulo 2^LW.
- R4: Opcode 2 (signed less-than), 3 (equal) and 4 (not equal) write the lane-i result into bit i of predicate register `in_mdst`. A compare makes no register writeback (`wb_en` = 0).
- R5: When `in_zero` = 0 (merge), a lane whose predicate bit is 0 carries its `dst_old` value on `wb_data`.
- R6: When `in_zero` = 1 (zeroing), a lane whose predicate bit is 0 is written as 0.
- R7: `in_msel` = 0 selects an all-ones predicate. A compare whose `in_mdst` is 0 changes no predicate register.
- R8: Each accepted instruction (`in_valid` = 1 at a rising edge) gives exactly one `done` pulse in the next cycle. For add and subtract, `wb_en` = 1 and `wb_idx` = `in_dst` in that same cycle.
- R9: Opcodes 5..7 pulse `done` but write neither the register file (`wb_en` = 0) nor any predicate register.
- R10: An add or subtract accepted in the cycle right after a compare already sees the predicate that the compare wrote.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_op | input | 3 | Opcode: 0 add, 1 sub, 2 signed lt, 3 eq, 4 ne |
| in_dst | input | VI | Destination vector register index |
| in_mdst | input | MI | Predicate register written by a compare |
| in_msel | input | MI | Predicate register used by add/sub |
| in_zero | input | 1 | 1 = zero masked-off lanes, 0 = merge |
| src_a | input | LANES*LW | First source vector |
| src_b | input | LANES*LW | Second source vector |
| dst_old | input | LANES*LW | Current contents of the destination register |
| done | output | 1 | One-cycle completion pulse |
| wb_en | output | 1 | Register file write enable |
| wb_idx | output | VI | Register file write index |
| wb_data | output | LANES*LW | Register file write data |

## Verification
A corrupted predicate register is invisible while it is being written. It shows up only in the first add or subtract that selects it: one or more lanes come back as the merged old value or as zero where the sum was due, or the reverse. That can be as soon as the cycle after the compare. The bench therefore tracks its own copy of every predicate register and follows compares with predicated arithmetic in both modes, using all-zero, all-ones and random masks. A wrong `done` or write enable shows up one cycle after acceptance, as a missing or extra scoreboard item.

// File: rtl/masked_lane_alu.sv
module masked_lane_alu #(
  parameter int LANES = 8,
  parameter int LW    = 8,
  parameter int NMASK = 8,
  parameter int NVREG = 8,
  localparam int VW = LANES * LW,
  localparam int MI = $clog2(NMASK),
  localparam int VI = $clog2(NVREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [2:0]    in_op,
  input  logic [VI-1:0] in_dst,
  input  logic [MI-1:0] in_mdst,
  input  logic [MI-1:0] in_msel,
  input  logic          in_zero,
  input  logic [VW-1:0] src_a,
  input  logic [VW-1:0] src_b,
  input  logic [VW-1:0] dst_old,
  output logic          done,
  output logic          wb_en,
  output logic [VI-1:0] wb_idx,
  output logic [VW-1:0] wb_data
);
  localparam logic [2:0] OP_ADD = 3'd0, OP_SUB = 3'd1,
                         OP_CLT = 3'd2, OP_CEQ = 3'd3, OP_CNE = 3'd4;

  logic [LANES-1:0] mreg [NMASK];
  logic [LANES-1:0] pred, cmp_bits;
  logic [VW-1:0]    res;

  wire is_arith = (in_op == OP_ADD) || (in_op == OP_SUB);
  wire is_cmp   = (in_op == OP_CLT) || (in_op == OP_CEQ) || (in_op == OP_CNE);

  assign pred = (in_msel == '0) ? '1 : mreg[in_msel];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    wire [LW-1:0] a   = src_a[i*LW +: LW];
    wire [LW-1:0] b   = src_b[i*LW +: LW];
    wire [LW-1:0] sum = (in_op == OP_SUB) ? a - b : a + b;
    wire          lt  = $signed(a) < $signed(b);
    wire          eq  = (a == b);
    assign cmp_bits[i] = (in_op == OP_CLT) ? lt : (in_op == OP_CEQ) ? eq : !eq;
    assign res[i*LW +: LW] = pred[i] ? sum : (in_zero ? '0 : dst_old[i*LW +: LW]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done    <= 1'b0;
      wb_en   <= 1'b0;
      wb_idx  <= '0;
      wb_data <= '0;
      for (int m = 0; m < NMASK; m++) mreg[m] <= '0;
    end else begin
      done  <= in_valid;
      wb_en <= in_valid && is_arith;
      if (in_valid) begin
        wb_idx  <= in_dst;
        wb_data <= is_arith ? res : '0;
        if (is_cmp && in_mdst != '0) mreg[in_mdst] <= cmp_bits;
      end
    end
  end
endmodule

// File: rtl/masked_lane_alu_chk.sv
module masked_lane_alu_chk #(
  parameter int LANES = 8,
  parameter int LW    = 8,
  parameter int MI    = 3,
  parameter int VI    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [2:0]    in_op,
  input logic [VI-1:0] in_dst,
  input logic [MI-1:0] in_msel,
  input logic [LANES*LW-1:0] src_a,
  input logic [LANES*LW-1:0] src_b,
  input logic          done,
  input logic          wb_en,
  input logic [VI-1:0] wb_idx,
  input logic [LANES*LW-1:0] wb_data
);
  AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> done); // R8
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !done); // R8
  AST_WB_IMPLIES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> done); // R8
  AST_NO_WB_NON_ARITH: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op > 3'd1) |=> !wb_en); // R9
  AST_WB_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op <= 3'd1) |=> (wb_en && wb_idx == $past(in_dst))); // R8
  AST_K0_FULL_ADD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 3'd0 && in_msel == '0 && src_b == '0) |=> wb_data == $past(src_a)); // R7
endmodule

bind masked_lane_alu masked_lane_alu_chk #(.LANES(LANES), .LW(LW), .MI(MI), .VI(VI)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op), .in_dst(in_dst),
  .in_msel(in_msel), .src_a(src_a), .src_b(src_b), .done(done), .wb_en(wb_en),
  .wb_idx(wb_idx), .wb_data(wb_data));

// File: tb/test_masked_lane_alu.sv
module test_masked_lane_alu;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 8, LW = 8, NMASK = 8;
  localparam int VW = LANES * LW;

  typedef struct {
    logic          en;
    logic [2:0]    idx;
    logic [VW-1:0] data;
    string         tag;
  } item_t;

  logic clk = 0, rst_n = 0, in_valid = 0, in_zero = 0;
  logic [2:0] in_op = 0, in_dst = 0, in_mdst = 0, in_msel = 0;
  logic [VW-1:0] src_a = 0, src_b = 0, dst_old = 0;
  logic done, wb_en;
  logic [2:0] wb_idx;
  logic [VW-1:0] wb_data;

  int checks = 0, failures = 0, cycles = 0;
  item_t q[$];
  logic [LANES-1:0] bmask [NMASK];

  masked_lane_alu i_masked_lane_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op), .in_dst(in_dst),
    .in_mdst(in_mdst), .in_msel(in_msel), .in_zero(in_zero), .src_a(src_a),
    .src_b(src_b), .dst_old(dst_old), .done(done), .wb_en(wb_en),
    .wb_idx(wb_idx), .wb_data(wb_data));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(bit ok, string tag, logic [VW-1:0] act, logic [VW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [2:0] dst, input logic [2:0] mdst,
                       input logic [2:0] msel, input logic zero, input logic [VW-1:0] a,
                       input logic [VW-1:0] b, input logic [VW-1:0] old, input string tag);
    item_t it;
    logic [LANES-1:0] p, cb;
    p = (msel == 0) ? '1 : bmask[msel];
    it.en = (op <= 3'd1);
    it.idx = dst;
    it.data = '0;
    it.tag = tag;
    for (int i = 0; i < LANES; i++) begin
      logic [LW-1:0] x, y, r;
      x = a[i*LW +: LW];
      y = b[i*LW +: LW];
      r = (op == 3'd1) ? x - y : x + y;
      if (it.en) it.data[i*LW +: LW] = p[i] ? r : (zero ? '0 : old[i*LW +: LW]);
      cb[i] = (op == 3'd2) ? ($signed(x) < $signed(y)) : (op == 3'd3) ? (x == y) : (x != y);
    end
    if (op >= 3'd2 && op <= 3'd4 && mdst != 0) bmask[mdst] = cb;
    in_valid = 1; in_op = op; in_dst = dst; in_mdst = mdst; in_msel = msel;
    in_zero = zero; src_a = a; src_b = b; dst_old = old;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic idle(int n);
    in_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [VW-1:0] rv();
    return {$urandom, $urandom};
  endfunction

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q.size() == 0) check(0, "R8 unexpected done", {63'd0, done}, '0);
      else begin
        item_t it;
        it = q.pop_front();
        check(wb_en === it.en, {it.tag, " wb_en"}, {63'd0, wb_en}, {63'd0, it.en});
        if (it.en) check(wb_idx === it.idx, {it.tag, " wb_idx"}, {61'd0, wb_idx}, {61'd0, it.idx});
        check(wb_data === it.data, {it.tag, " wb_data"}, wb_data, it.data);
      end
    end
  end

  initial begin
    @(negedge clk);
    cycles = 0;
    while (cycles < 100000) begin
      @(negedge clk);
      cycles++;
    end
    check(0, "watchdog", '0, '0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  localparam logic [VW-1:0] ONES8 = {LANES{8'h01}};

  initial begin
    for (int m = 0; m < NMASK; m++) bmask[m] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(done === 0 && wb_en === 0, "R1 reset done/wb_en", {62'd0, done, wb_en}, '0);
    check(wb_data === '0, "R1 reset wb_data", wb_data, '0);
    issue(0, 3'd2, 0, 3'd5, 0, rv(), rv(), 64'hCAFE_F00D_1234_5678, "R1");
    issue(0, 3'd1, 0, 0, 0, {LANES{8'hFF}}, ONES8, rv(), "R2 wrap");
    issue(1, 3'd3, 0, 0, 0, {LANES{8'h00}}, ONES8, rv(), "R3 wrap");
    // compare into register 0 must not change the all-ones predicate
    issue(3, 0, 0, 0, 0, ONES8, ~ONES8, rv(), "R7 cmp k0");
    issue(0, 3'd4, 0, 0, 1, rv(), rv(), rv(), "R7 k0 pred");
    // signed lt: 0x80 (-128) < 0x7F true; 0x7F < 0x80 false, alternating lanes
    issue(2, 0, 3'd1, 0, 0, {4{8'h80, 8'h7F}}, {4{8'h7F, 8'h80}}, '0, "R4 lt");
    issue(0, 3'd5, 0, 3'd1, 1, rv(), rv(), rv(), "R10 lt then add");
    issue(3, 0, 3'd2, 0, 0, 64'h11_22_33_44_55_66_77_88, 64'h11_00_33_00_55_00_77_00, '0, "R4 eq");
    issue(1, 3'd6, 0, 3'd2, 0, rv(), rv(), rv(), "R10 eq then sub");
    issue(4, 0, 3'd3, 0, 0, 64'h5, 64'h5, '0, "R4 ne");
    issue(0, 3'd7, 0, 3'd3, 0, rv(), rv(), rv(), "R4 ne used");
    // all-ones (eq a==a) and all-zero (ne a==a) masks
    issue(3, 0, 3'd4, 0, 0, 64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF, '0, "R4 all ones");
    issue(4, 0, 3'd5, 0, 0, 64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF, '0, "R4 all zero");
    issue(0, 3'd1, 0, 3'd4, 0, rv(), rv(), rv(), "R5 ones merge");
    issue(0, 3'd1, 0, 3'd5, 0, rv(), rv(), rv(), "R5 zero merge");
    issue(1, 3'd1, 0, 3'd5, 1, rv(), rv(), rv(), "R6 zero zeroing");
    issue(1, 3'd1, 0, 3'd4, 1, rv(), rv(), rv(), "R6 ones zeroing");
    // unknown opcodes must not touch a predicate register
    issue(3'd6, 3'd2, 3'd4, 0, 0, rv(), rv(), rv(), "R9 op6");
    issue(3'd7, 3'd2, 3'd5, 0, 0, 64'h1, 64'h2, rv(), "R9 op7");
    idle(1);
    issue(0, 3'd3, 0, 3'd4, 1, rv(), rv(), rv(), "R9 k4 kept");
    issue(0, 3'd3, 0, 3'd5, 1, rv(), rv(), rv(), "R9 k5 kept");
    for (int n = 0; n < 400; n++) begin
      logic [2:0] op;
      logic [VW-1:0] a, b;
      op = 3'($urandom_range(0, 4));
      a = rv();
      b = ($urandom_range(0, 3) == 0) ? a ^ (rv() & rv() & rv()) : rv();
      issue(op, 3'($urandom), 3'($urandom), 3'($urandom), 1'($urandom), a, b, rv(),
            (op == 0) ? "R2 rand" : (op == 1) ? "R3 rand" : "R4 rand");
      if ($urandom_range(0, 4) == 0) idle(1);
    end
    idle(3);
    check(q.size() == 0, "R8 all done", 64'(q.size()), '0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule